// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Channel Divider

This block divides a fast input clock into a slower output clock whose high time and low time are set independently, each from 1 to 16 input cycles. Every division ratio from 2 to 32 can therefore be split between high and low in any way. A single configuration bit bypasses the counters so that the input clock reaches the output unchanged, which gives divide-by-1.

A synchronous sync pulse captures every configuration field into a shadow register and restarts the sequencer. The output is then held low for a programmable number of input cycles (0 to 31) and starts in the high or the low phase, as programmed. Several channels that share one sync pulse therefore align their edges with a chosen coarse skew. Configuration inputs that change between sync pulses have no effect, so reprogramming cannot cut a phase short.

An optional correction stage ORs the output with a copy of itself retimed on the falling input-clock edge. This stretches each high phase by half an input cycle and shortens the low phase by the same amount. An odd ratio programmed with low count = high count + 1 then becomes an exact 50% duty cycle.

Top module: `clkdiv_chan`

## Requirements
- R1: While rst_ni is low, clk_o is low. After release and with no sync, the shadow configuration is all zero: the first rising clock edge drives clk_o high, and it then toggles every input cycle (divide-by-2). Configuration inputs are ignored until the first sync.
- R2: In divide mode the high phase lasts high_cnt_i+1 input cycles, where high_cnt_i is a 4-bit field (0..15).
- R3: In divide mode the low phase lasts low_cnt_i+1 input cycles, where low_cnt_i is a 4-bit field (0..15). The period is high_cnt_i+low_cnt_i+2 cycles.
- R4: Changes on bypass_i, high_cnt_i, low_cnt_i, delay_i, start_high_i and dcc_en_i while sync_i is low leave clk_o unchanged.
- R5: At a rising edge where sync_i is high with delay_i = d (5 bits, 0..31), clk_o goes low and stays low for d input cycles. The start phase begins at the d-th following edge; for d = 0 it begins at the sync edge itself.
- R6: With start_high_i = 1 the first phase after the delay is high. With start_high_i = 0 it is a low phase of low_cnt_i+1 cycles, so the first rising edge comes d+low_cnt_i+1 cycles after the sync edge.
- R7: With bypass_i = 1 captured at sync, clk_o equals clk_i in both halves of every input cycle.
- R8: With dcc_en_i = 1 captured at sync, each rising edge of clk_o keeps its position. Each falling edge moves to the falling input edge half a cycle later than without correction.
- R9: A sync pulse loads all fields sampled at that edge and restarts the counters, whatever phase the output is in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronous load and restart pulse |
| bypass_i | input | 1 | 1 = divide-by-1, input clock routed to output |
| high_cnt_i | input | 4 | High time minus one, in input cycles |
| low_cnt_i | input | 4 | Low time minus one, in input cycles |
| delay_i | input | 5 | Coarse start delay in input cycles |
| start_high_i | input | 1 | 1 = start in high phase after the delay |
| dcc_en_i | input | 1 | 1 = half-cycle duty-cycle correction |
| clk_o | output | 1 | Divided clock |

## Verification
A corrupted phase counter shows up within one period as a high or low run of the wrong length. A wrong delay count or start level shifts every later edge, which the bench sees on the first transition after sync. A stale or corrupted shadow register shows up at the first phase reload after the sync edge, as a period or duty cycle that does not match. A fault in the correction flop shows up within one period as a missing or misplaced half-cycle stretch, which sampling in both clock halves detects.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CNT_W = 4;
  localparam int DLY_W = 5;
  localparam int LEN_W = CNT_W + 1;

  typedef struct packed {
    logic             bypass;
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic [DLY_W-1:0] dly;
    logic             start_hi;
    logic             dcc_en;
  } div_cfg_t;
endpackage

// File: rtl/clkdiv_shadow.sv
module clkdiv_shadow
  import clkdiv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sync_i,
  input  div_cfg_t cfg_i,
  output div_cfg_t cfg_o
);
  div_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (sync_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(cfg_o)); // R4
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
  import clkdiv_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sync_i,
  input  div_cfg_t ld_cfg_i,  // raw fields, taken at sync
  input  div_cfg_t cfg_i,     // shadow fields, used while running
  output logic     q_o
);
  logic             run_q, run_d;
  logic             q_q, q_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DLY_W-1:0] wait_q, wait_d;
  logic [LEN_W-1:0] len_q, len_d;

  localparam logic [DLY_W-1:0] DLY_ONE = {{(DLY_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] first_cnt(div_cfg_t c);
    return c.start_hi ? c.hi : c.lo;
  endfunction

  always_comb begin
    run_d  = run_q;
    q_d    = q_q;
    cnt_d  = cnt_q;
    wait_d = wait_q;
    if (sync_i) begin
      if (ld_cfg_i.dly == '0) begin
        run_d = 1'b1;
        q_d   = ld_cfg_i.start_hi;
        cnt_d = first_cnt(ld_cfg_i);
      end else begin
        run_d  = 1'b0;
        q_d    = 1'b0;
        wait_d = ld_cfg_i.dly - DLY_ONE;
      end
    end else if (!run_q) begin
      if (wait_q == '0) begin
        run_d = 1'b1;
        q_d   = cfg_i.start_hi;
        cnt_d = first_cnt(cfg_i);
      end else begin
        wait_d = wait_q - DLY_ONE;
      end
    end else if (cnt_q == '0) begin
      q_d   = ~q_q;
      cnt_d = q_q ? cfg_i.lo : cfg_i.hi;
    end else begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  // age of the current output level, guards phase lengths
  always_comb begin
    if (sync_i || (q_d != q_q) || (run_d && !run_q)) len_d = '0;
    else if (len_q != '1)                             len_d = len_q + 1'b1;
    else                                              len_d = len_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b1;
      q_q    <= 1'b0;
      cnt_q  <= '0;
      wait_q <= '0;
      len_q  <= '0;
    end else begin
      run_q  <= run_d;
      q_q    <= q_d;
      cnt_q  <= cnt_d;
      wait_q <= wait_d;
      len_q  <= len_d;
    end
  end

  assign q_o = q_q;

  AST_HI_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && q_q) |-> (len_q <= {1'b0, cfg_i.hi})); // R2
  AST_LO_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !q_q) |-> (len_q <= {1'b0, cfg_i.lo})); // R3
  AST_WAIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !q_o); // R5
endmodule

// File: rtl/clkdiv_dcc.sv
module clkdiv_dcc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic q_i,
  output logic clk_o
);
  logic q_neg_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_neg_q <= 1'b0;
    else         q_neg_q <= q_i;
  end

  assign clk_o = en_i ? (q_i | q_neg_q) : q_i;

  // retimed copy must lag by exactly half a cycle
  AST_DCC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_neg_q == q_i); // R8
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sync_i,
  input  logic                          bypass_i,
  input  logic [clkdiv_pkg::CNT_W-1:0]  high_cnt_i,
  input  logic [clkdiv_pkg::CNT_W-1:0]  low_cnt_i,
  input  logic [clkdiv_pkg::DLY_W-1:0]  delay_i,
  input  logic                          start_high_i,
  input  logic                          dcc_en_i,
  output logic                          clk_o
);
  import clkdiv_pkg::*;

  div_cfg_t raw_cfg, sh_cfg;
  logic     seq_q, dcc_out;

  assign raw_cfg = '{bypass: bypass_i, hi: high_cnt_i, lo: low_cnt_i,
                     dly: delay_i, start_hi: start_high_i, dcc_en: dcc_en_i};

  clkdiv_shadow u_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .cfg_i  (raw_cfg),
    .cfg_o  (sh_cfg)
  );

  clkdiv_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .ld_cfg_i (raw_cfg),
    .cfg_i    (sh_cfg),
    .q_o      (seq_q)
  );

  clkdiv_dcc u_dcc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sh_cfg.dcc_en),
    .q_i    (seq_q),
    .clk_o  (dcc_out)
  );

  assign clk_o = sh_cfg.bypass ? clk_i : dcc_out;
endmodule

// File: tb/sim_clkdiv_chan.sv
module sim_clkdiv_chan;
  localparam int PER = 10;
  localparam int QTR = PER / 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic       byp = 1'b0;
  logic [3:0] hi = 4'd7;
  logic [3:0] lo = 4'd3;
  logic [4:0] dly = 5'd9;
  logic       st = 1'b1;
  logic       dcc = 1'b1;
  logic       clk_out;

  int checks = 0;
  int errors = 0;

  always #(PER/2) clk = ~clk;

  clkdiv_chan u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sync_i       (sync),
    .bypass_i     (byp),
    .high_cnt_i   (hi),
    .low_cnt_i    (lo),
    .delay_i      (dly),
    .start_high_i (st),
    .dcc_en_i     (dcc),
    .clk_o        (clk_out)
  );

  function automatic bit exp_q(int k, int h, int l, int d, bit s);
    int j;
    if (k < d) return 1'b0;
    j = (k - d) % (h + l + 2);
    if (s) return j < h + 1;
    return j >= l + 1;
  endfunction

  // one sync, then a waveform check over d + two periods; inputs are
  // scrambled right after the sync edge (R4)
  task automatic run_cfg(bit b, int h, int l, int d, bit s, bit c, string tag);
    bit ok = 1'b1;
    bit sa, sb, ea, eb;
    int kk = 0, hf = 0;
    bit aa = 1'b0, ee = 1'b0;
    int n = d + 2 * (h + l + 2) + 2;
    @(negedge clk);
    byp = b; hi = 4'(h); lo = 4'(l); dly = 5'(d); st = s; dcc = c; sync = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #(QTR); sa = clk_out;
      @(negedge clk);
      if (k == 0) begin
        sync = 1'b0;
        byp = ~b; hi = ~hi; lo = ~lo; dly = ~dly; st = ~s; dcc = ~c;
      end
      #(QTR); sb = clk_out;
      if (b) begin
        ea = 1'b1; eb = 1'b0;
      end else begin
        eb = exp_q(k, h, l, d, s);
        ea = (c && k > 0) ? (eb | exp_q(k - 1, h, l, d, s)) : eb;
      end
      if (ok && !(c && !b && k == 0) && sa != ea) begin
        ok = 1'b0; kk = k; hf = 0; aa = sa; ee = ea;
      end
      if (ok && sb != eb) begin
        ok = 1'b0; kk = k; hf = 1; aa = sb; ee = eb;
      end
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s b=%0b h=%0d l=%0d d=%0d s=%0b c=%0b cycle=%0d half=%0d act=%0b exp=%0b",
               tag, b, h, l, d, s, c, kk, hf, aa, ee);
    end
  endtask

  initial begin
    bit ok;
    int kk;
    // R1: reset holds output low, inputs ignored before first sync
    repeat (3) @(negedge clk);
    #(QTR);
    checks++;
    if (clk_out !== 1'b0) begin
      errors++;
      $display("FAIL R1 during reset act=%0b exp=0", clk_out);
    end
    @(negedge clk);
    rst_n = 1'b1;
    ok = 1'b1; kk = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #(QTR);
      if (ok && clk_out !== bit'(k % 2 == 0)) begin ok = 1'b0; kk = k; end
      @(negedge clk); #(QTR);
      if (ok && clk_out !== bit'(k % 2 == 0)) begin ok = 1'b0; kk = k; end
    end
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R1 divide-by-2 after reset cycle=%0d act=%0b exp=%0b",
               kk, clk_out, bit'(kk % 2 == 0));
    end

    // R2 R3 R6 R9: every high/low split, both start levels, varied delay
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++)
        for (int s = 0; s < 2; s++)
          run_cfg(1'b0, h, l, (h * 7 + l * 3 + s * 11) % 32, bit'(s), 1'b0, "R2/R3/R6/R9");

    // R5: every delay value with both start levels
    for (int d = 0; d < 32; d++)
      for (int s = 0; s < 2; s++)
        run_cfg(1'b0, 2, 5, d, bit'(s), 1'b0, "R5/R6");

    // R7: bypass, then back to dividing
    run_cfg(1'b1, 4, 4, 0, 1'b1, 1'b0, "R7");
    run_cfg(1'b0, 3, 1, 0, 1'b1, 1'b0, "R7/R9");

    // R8: correction on odd ratios with M = N + 1, plus uneven splits
    for (int n = 0; n < 15; n++)
      for (int s = 0; s < 2; s++)
        run_cfg(1'b0, n, n + 1, n % 4, bit'(s), 1'b1, "R8");
    run_cfg(1'b0, 0, 0, 0, 1'b1, 1'b1, "R8");
    run_cfg(1'b0, 6, 2, 3, 1'b0, 1'b1, "R8");

    // R4: explicit hold check, long config then idle with scrambled inputs
    run_cfg(1'b0, 9, 12, 17, 1'b0, 1'b0, "R4");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PER * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule